// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line and presents each one as a parallel word to a host. The block runs on its system clock. A separate receiver clock, running at sixteen times the bit rate, is brought into that domain, and each of its rising edges becomes one sample tick. The serial input passes through its own synchronizer. Three static controls set the frame: character length, whether a parity bit is present, and whether the parity is even or odd.

The receiver waits for the line to go low. It confirms the start bit at its mid-point and then reads every later bit at its centre. It checks the parity bit and the first stop bit, and it recognises a line held low for a whole character as a break. A finished character lands in a receive buffer and pulls an active-low ready output low. A one-cycle host read pulse empties the buffer. The error flags accumulate until that read.

Top module: `uart_rx_sync`

## Requirements
- R1: A low level seen on the line while idle starts a character. If the line is high again at the mid-point of the start bit, 8 ticks after detection, the character is abandoned and nothing is loaded.
- R2: The first data bit is sampled 24 ticks after start detection, and each later bit 16 ticks after the one before it. A disturbance confined to the first quarter of a bit therefore does not corrupt the data.
- R3: char_sel_i selects 5, 6, 7 or 8 data bits (00, 01, 10, 11). Bits arrive least significant first. Buffer bits above the character length read as zero.
- R4: When par_en_i is 1, a parity bit follows the data. With par_even_i=1 the data and parity bits together must hold an even number of ones; with par_even_i=0 they must hold an odd number. A mismatch still loads the character and sets parity_err_o.
- R5: Only the first stop bit is examined. If it is low while some earlier data or parity bit was high, framing_err_o is set and the buffer and ready output are left unchanged.
- R6: A character that completes while the buffer is still full replaces the buffered one and sets overrun_o.
- R7: rx_ready_no goes low in the cycle after a character is loaded. It returns high after a rd_i pulse on which no new character is loaded.
- R8: A character in which the start, data, parity and first stop samples are all low loads 0x00 and sets break_o. No further character is started until the line has returned high.
- R9: After reset, rbr_o is 0x00, rx_ready_no is 1, and all four error flags are 0.
- R10: The error flags stay set until a rd_i pulse clears them. A flag raised in the same cycle as the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rclk_i | input | 1 | Receiver clock at 16x bit rate, asynchronous to clk_i |
| serial_i | input | 1 | Serial line, idle high |
| char_sel_i | input | 2 | Character length select: 00=5, 01=6, 10=7, 11=8 bits |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| rd_i | input | 1 | Host read pulse, one cycle; empties the buffer and clears the flags |
| rbr_o | output | 8 | Receive buffer |
| rx_ready_no | output | 1 | Low while a character is waiting |
| overrun_o | output | 1 | Overrun flag |
| parity_err_o | output | 1 | Parity error flag |
| framing_err_o | output | 1 | Framing error flag |
| break_o | output | 1 | Break flag |

## Verification
Clean frames at every character length show that the received word is assembled least significant bit first and zero-extended. A frame whose data bits each carry an inverted glitch at their leading edge separates centre sampling from edge sampling. Parity frames are sent in matching and flipped form under both even and odd settings, which tests the sense of the check. Four patterns exercise the error paths:
- a short low pulse, for false-start rejection;
- a low stop bit after non-zero data, for a framing error with no load;
- a line held low for longer than a character, for a break followed by a clean restart;
- two back-to-back frames with no read between them, for overrun.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK
  } rx_state_e;

  function automatic logic [3:0] char_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rclk_i,
  input  logic serial_i,
  output logic tick_o,
  output logic rx_o
);
  logic [SYNC-1:0] rclk_q, ser_q;
  logic            rclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rclk_q <= '0;
      ser_q  <= '1;
      rclk_d <= 1'b0;
    end else begin
      rclk_q <= {rclk_q[SYNC-2:0], rclk_i};
      ser_q  <= {ser_q[SYNC-2:0], serial_i};
      rclk_d <= rclk_q[SYNC-1];
    end
  end

  assign tick_o = rclk_q[SYNC-1] & ~rclk_d;
  assign rx_o   = ser_q[SYNC-1];

  // ticks are isolated pulses
  assert_tick_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [1:0]    char_sel_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  output logic          load_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          brk_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] MID = CW'(OS / 2 - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q;
  logic [DW-1:0] sh_q;
  logic          par_q, any_q;
  logic          samp;
  logic [3:0]    nbits;

  assign nbits = char_bits(char_sel_i);
  // free-running phase: 8 ticks to start centre, then every 16
  assign samp  = tick_i && (cnt_q == MID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      any_q   <= 1'b0;
      load_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      brk_o   <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      ferr_o <= 1'b0;
      if (state_q == RX_IDLE) cnt_q <= '0;
      else if (tick_i)        cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: if (tick_i && !rx_i) begin
          state_q <= RX_START;
          idx_q   <= '0;
          par_q   <= 1'b0;
          any_q   <= 1'b0;
        end
        RX_START: if (samp) state_q <= rx_i ? RX_IDLE : RX_DATA;
        RX_DATA: if (samp) begin
          sh_q  <= {rx_i, sh_q[DW-1:1]};
          par_q <= par_q ^ rx_i;
          any_q <= any_q | rx_i;
          idx_q <= idx_q + 1'b1;
          if (idx_q == nbits - 4'd1) state_q <= par_en_i ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (samp) begin
          par_q   <= par_q ^ rx_i;
          any_q   <= any_q | rx_i;
          state_q <= RX_STOP;
        end
        RX_STOP: if (samp) begin
          if (rx_i) begin
            load_o  <= 1'b1;
            data_o  <= sh_q >> (DW - int'(nbits));
            perr_o  <= par_en_i & (par_q ^ ~par_even_i);
            brk_o   <= 1'b0;
            state_q <= RX_IDLE;
          end else if (!any_q) begin
            load_o  <= 1'b1;
            data_o  <= '0;
            perr_o  <= 1'b0;
            brk_o   <= 1'b1;
            state_q <= RX_BRK;
          end else begin
            ferr_o  <= 1'b1;
            state_q <= RX_IDLE;
          end
        end
        RX_BRK: if (rx_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assert_brk_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_BRK && !rx_i) |=> state_q == RX_BRK);
  assert_brk_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && brk_o) |-> data_o == '0);
  assert_false_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && samp && rx_i) |=> (state_q == RX_IDLE && !load_o));
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          perr_i,
  input  logic          brk_i,
  input  logic          ferr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rbr_o,
  output logic          rx_ready_no,
  output logic          overrun_o,
  output logic          parity_err_o,
  output logic          framing_err_o,
  output logic          break_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_o         <= '0;
      full_q        <= 1'b0;
      overrun_o     <= 1'b0;
      parity_err_o  <= 1'b0;
      framing_err_o <= 1'b0;
      break_o       <= 1'b0;
    end else begin
      if (rd_i) begin
        full_q        <= 1'b0;
        overrun_o     <= 1'b0;
        parity_err_o  <= 1'b0;
        framing_err_o <= 1'b0;
        break_o       <= 1'b0;
      end
      // set after clear: new events survive a same-cycle read
      if (load_i) begin
        rbr_o  <= data_i;
        full_q <= 1'b1;
        if (full_q && !rd_i) overrun_o    <= 1'b1;
        if (perr_i)          parity_err_o <= 1'b1;
        if (brk_i)           break_o      <= 1'b1;
      end
      if (ferr_i) framing_err_o <= 1'b1;
    end
  end

  assign rx_ready_no = ~full_q;

  assert_ready_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !rx_ready_no);
  assert_ready_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i) |=> rx_ready_no);
  assert_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !rx_ready_no && !rd_i) |=> overrun_o);
  assert_ferr_noload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_i && !load_i) |=> $stable(rbr_o));
  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o && !rd_i) |=> parity_err_o);
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rclk_i,
  input  logic              serial_i,
  input  logic [1:0]        char_sel_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rbr_o,
  output logic              rx_ready_no,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              framing_err_o,
  output logic              break_o
);
  logic              tick, rx;
  logic              load, perr, brk, ferr;
  logic [DATA_W-1:0] data;

  rx_tick_gen #(.SYNC(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .rclk_i, .serial_i,
    .tick_o(tick), .rx_o(rx)
  );

  rx_frame_fsm #(.DW(DATA_W), .OS(OVERSAMPLE)) u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx),
    .char_sel_i, .par_en_i, .par_even_i,
    .load_o(load), .data_o(data), .perr_o(perr), .brk_o(brk), .ferr_o(ferr)
  );

  rx_holding #(.DW(DATA_W)) u_hold (
    .clk_i, .rst_ni, .load_i(load), .data_i(data),
    .perr_i(perr), .brk_i(brk), .ferr_i(ferr), .rd_i,
    .rbr_o, .rx_ready_no, .overrun_o, .parity_err_o, .framing_err_o, .break_o
  );

  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && char_sel_i == 2'b00) |=> rbr_o[DATA_W-1:5] == '0);
  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load && ferr));
endmodule

// File: tb/tb_uart_rx_sync.sv
module tb_uart_rx_sync;
  localparam int BIT_CLK = 64;  // 16 ticks x 4 clk

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rclk = 1'b0;
  logic       serial = 1'b1;
  logic [1:0] char_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] rbr;
  logic       ready_n, ovr, perr, ferr, brk;

  always #2 clk = ~clk;
  always begin
    repeat (2) @(posedge clk);
    rclk = ~rclk;
  end

  uart_rx_sync dut (
    .clk_i(clk), .rst_ni, .rclk_i(rclk), .serial_i(serial),
    .char_sel_i(char_sel), .par_en_i(par_en), .par_even_i(par_even), .rd_i(rd),
    .rbr_o(rbr), .rx_ready_no(ready_n), .overrun_o(ovr), .parity_err_o(perr),
    .framing_err_o(ferr), .break_o(brk)
  );

  typedef struct packed { logic [7:0] d; logic pe; logic bk; } exp_t;
  exp_t exp_q[$];
  int   errs = 0, checks = 0;
  bit   auto_rd = 1'b0, done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    serial = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input int len, input bit pflip,
                      input bit stop_ok, input bit glitch);
    logic [7:0] dm;
    logic p;
    dm = d & 8'((1 << len) - 1);
    p  = ^dm;
    if (!par_even) p = ~p;
    if (pflip) p = ~p;
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < len; i++) begin
      if (glitch) begin
        hold(~dm[i], 8);
        hold(dm[i], BIT_CLK - 8);
      end else hold(dm[i], BIT_CLK);
    end
    if (par_en) hold(p, BIT_CLK);
    if (stop_ok) hold(1'b1, 2 * BIT_CLK);
    else begin
      hold(1'b0, 48);
      hold(1'b1, 2 * BIT_CLK);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic bk);
    exp_q.push_back('{d: d, pe: pe, bk: bk});
  endtask

  // monitor: pop and compare on every load, then read
  initial forever begin
    @(negedge clk);
    if (auto_rd && ready_n === 1'b0) begin
      if (exp_q.size() == 0) chk("R5/R8", "unexpected load", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R3", "data", rbr, e.d);
        chk("R4", "parity flag", perr, e.pe);
        chk("R8", "break flag", brk, e.bk);
        chk("R6", "no overrun", ovr, 0);
      end
      rd = 1'b1;
      @(negedge clk) rd = 1'b0;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "rbr", rbr, 0);
    chk("R9", "ready_n", ready_n, 1);
    chk("R9", "flags", {ovr, perr, ferr, brk}, 0);
    auto_rd = 1'b1;
    repeat (BIT_CLK) @(negedge clk);

    // R3: 8 bits, no parity
    push(8'hA5, 0, 0); send(8'hA5, 8, 0, 1, 0);
    push(8'h3C, 0, 0); send(8'h3C, 8, 0, 1, 0);
    // R2: leading-edge glitches on every data bit
    push(8'h5A, 0, 0); send(8'h5A, 8, 0, 1, 1);
    push(8'hC3, 0, 0); send(8'hC3, 8, 0, 1, 1);
    // R3: shorter characters
    char_sel = 2'b00; push(8'h1F, 0, 0); send(8'hFF, 5, 0, 1, 0);
    char_sel = 2'b01; push(8'h2A, 0, 0); send(8'hEA, 6, 0, 1, 0);
    char_sel = 2'b10; push(8'h01, 0, 0); send(8'h81, 7, 0, 1, 0);
    char_sel = 2'b11;
    // R4: parity modes
    par_en = 1'b1; par_even = 1'b1;
    push(8'h37, 0, 0); send(8'h37, 8, 0, 1, 0);
    push(8'h37, 1, 0); send(8'h37, 8, 1, 1, 0);
    par_even = 1'b0;
    push(8'h37, 0, 0); send(8'h37, 8, 0, 1, 0);
    push(8'h36, 1, 0); send(8'h36, 8, 1, 1, 0);
    par_en = 1'b0; par_even = 1'b1;
    chk("R7", "queue drained", exp_q.size(), 0);

    // R1: false start
    hold(1'b0, 16);
    hold(1'b1, 3 * BIT_CLK);
    chk("R1", "ready after glitch", ready_n, 1);
    chk("R1", "no framing", ferr, 0);
    push(8'h66, 0, 0); send(8'h66, 8, 0, 1, 0);

    // R5: low stop bit
    send(8'h81, 8, 0, 0, 0);
    repeat (BIT_CLK) @(negedge clk);
    chk("R5", "framing flag", ferr, 1);
    chk("R5", "no load", ready_n, 1);
    repeat (BIT_CLK) @(negedge clk);
    chk("R10", "framing sticky", ferr, 1);
    rd_pulse();
    @(negedge clk);
    chk("R10", "framing cleared", ferr, 0);

    // R8: break with parity enabled
    par_en = 1'b1;
    push(8'h00, 0, 1);
    hold(1'b0, 14 * BIT_CLK);
    chk("R8", "break consumed", exp_q.size(), 0);
    hold(1'b1, 2 * BIT_CLK);
    push(8'h42, 0, 0); send(8'h42, 8, 0, 1, 0);
    par_en = 1'b0;
    chk("R8", "resync queue", exp_q.size(), 0);

    // R6: overrun
    auto_rd = 1'b0;
    send(8'h11, 8, 0, 1, 0);
    chk("R7", "ready low", ready_n, 0);
    chk("R6", "first no overrun", ovr, 0);
    send(8'h22, 8, 0, 1, 0);
    chk("R6", "overrun flag", ovr, 1);
    chk("R6", "newest kept", rbr, 8'h22);
    rd_pulse();
    @(negedge clk);
    chk("R7", "ready high after read", ready_n, 1);
    chk("R10", "overrun cleared", ovr, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule